// File: doc/BRIEF.md
# Sleep-Mode and Reset Qualification Controller

This block owns the two sleep-request bits of a small microcontroller and decides which clock domains run. A CPU write while the core is running can put the chip into idle or power-down. In idle the core clock is gated, and the oscillator and peripheral clocks keep running. In power-down all three enables are off.

Idle ends when an enabled interrupt request arrives. Hardware then clears the idle bit. Power-down ends only through a qualified external reset. The reset pin is first synchronised. It must then stay high for a fixed number of oscillator clocks before the internal reset is raised. Leaving power-down lets the oscillator run for a settling period before the core and peripheral clocks come back. Reset clears the mode bits but never requests a clear of RAM.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After the asynchronous reset is released, `cpu_clk_en`, `per_clk_en` and `osc_en` are high, `int_rst` is low and `mode_q` is 00.
- R2: A write accepted while running with data bit 0 = 1 and bit 1 = 0 enters idle on the next cycle. In idle `cpu_clk_en` is low, `per_clk_en` and `osc_en` stay high, and `mode_q` is 01. Data bits above bit 1 have no effect.
- R3: An accepted write with data bit 1 = 1 enters power-down on the next cycle, whatever bit 0 holds. `mode_q` then shows the written pair (11 or 10).
- R4: In idle, `irq_pend` high with `int_rst` low returns the block to running on the next cycle and clears `mode_q` bit 0.
- R5: In power-down, `osc_en`, `cpu_clk_en` and `per_clk_en` are all low, and `irq_pend` has no effect.
- R6: Writes are accepted only while `cpu_clk_en` is high and `int_rst` is low. Writes made in power-down or during oscillator settling change nothing. `irq_pend` while running changes nothing.
- R7: `int_rst` rises after the 26th rising edge on which `rst_pin` has been high without a break (2 synchroniser stages plus 24 qualification clocks). A low pin seen by the synchroniser restarts the count. `int_rst` falls after the third rising edge following the pin's fall.
- R8: Raised `int_rst` clears `mode_q` to 00 on the next cycle and sends idle back to running. From power-down, `osc_en` rises one cycle after `int_rst`. The core and peripheral enables stay low for STAB_CLKS cycles, then both rise together.
- R9: `ram_clr` is never asserted, including during and after any reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rst_pin | input | 1 | Raw external reset pin, active high |
| reg_wr | input | 1 | CPU write strobe to the sleep register |
| reg_wdata | input | DATA_W | Write data; bit 0 requests idle, bit 1 requests power-down |
| irq_pend | input | 1 | Any enabled interrupt pending |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Timer, serial and interrupt-logic clock enable |
| osc_en | output | 1 | Oscillator enable |
| int_rst | output | 1 | Qualified internal reset |
| ram_clr | output | 1 | RAM clear request, held low |
| mode_q | output | 2 | Sleep register bits {power-down, idle} |

## Verification
Writing both mode bits at once must end in power-down. A design that favours idle would leave `osc_en` high. A reset pin pulse of 20 clocks, a single low clock and then a full hold exercises the count restart. A counter that only pauses would raise `int_rst` several cycles early, and a counter that never restarts would raise it after the short pulse. The power-down exit is sampled on the exact last settling cycle and the first running cycle, so an off-by-one settle count, or a core clock returned together with the oscillator, shows up as a mismatch. Interrupts and writes in power-down and during settling must leave every output unchanged.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_IDLE  = 2'd1,
    PS_PDOWN = 2'd2,
    PS_WARM  = 2'd3
  } pwr_state_e;

  localparam int IDLE_BIT = 0;
  localparam int PDN_BIT  = 1;
endpackage

// File: rtl/pwr_rst_qual.sv
module pwr_rst_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CLKS   = 24
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pin_raw,
  output logic qual_rst
);
  localparam int CW = $clog2(QUAL_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CLKS - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_s;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   rst_q, rst_d;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
  end

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    if (!pin_s) begin
      cnt_d = '0;
      rst_d = 1'b0;
    end else begin
      rst_d = rst_q | (cnt_q == LAST);
      cnt_d = (cnt_q == LAST) ? cnt_q : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rst_q <= rst_d;
    end
  end

  assign qual_rst = rst_q;
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STAB_CLKS = 16
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_req,
  input  logic              qual_rst,
  output pwr_state_e        state_o,
  output logic [1:0]        mode_o
);
  localparam int SCW = $clog2(STAB_CLKS + 1);
  localparam logic [SCW-1:0] STAB_LAST = SCW'(STAB_CLKS - 1);

  pwr_state_e     state_q, state_d;
  logic [1:0]     mode_q, mode_d;
  logic [SCW-1:0] stab_q, stab_d;
  logic           stab_en;
  logic           unused_hi;

  assign unused_hi = ^wr_data;

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    stab_d  = stab_q;
    unique case (state_q)
      PS_RUN: begin
        if (qual_rst) begin
          mode_d = 2'b00;
        end else if (wr_en) begin
          mode_d = wr_data[1:0];
          if (wr_data[PDN_BIT])       state_d = PS_PDOWN;
          else if (wr_data[IDLE_BIT]) state_d = PS_IDLE;
        end
      end
      PS_IDLE: begin
        if (qual_rst) begin
          state_d = PS_RUN;
          mode_d  = 2'b00;
        end else if (irq_req) begin
          state_d          = PS_RUN;
          mode_d[IDLE_BIT] = 1'b0;
        end
      end
      PS_PDOWN: begin
        if (qual_rst) begin
          state_d = PS_WARM;
          mode_d  = 2'b00;
          stab_d  = '0;
        end
      end
      PS_WARM: begin
        mode_d = 2'b00;
        if (stab_q == STAB_LAST) state_d = PS_RUN;
        else                     stab_d  = stab_q + 1'b1;
      end
      default: state_d = PS_RUN;
    endcase
  end

  assign stab_en = (state_q == PS_WARM) || (state_q == PS_PDOWN);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= PS_RUN;
      mode_q  <= 2'b00;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      stab_q <= '0;
    else if (stab_en) stab_q <= stab_d;
  end

  assign state_o = state_q;
  assign mode_o  = mode_q;
endmodule

// File: rtl/pwr_enable_dec.sv
module pwr_enable_dec
  import pwr_pkg::*;
(
  input  pwr_state_e state_i,
  output logic       cpu_en,
  output logic       per_en,
  output logic       osc_on
);
  always_comb begin
    cpu_en = 1'b0;
    per_en = 1'b0;
    osc_on = 1'b0;
    unique case (state_i)
      PS_RUN:   begin cpu_en = 1'b1; per_en = 1'b1; osc_on = 1'b1; end
      PS_IDLE:  begin per_en = 1'b1; osc_on = 1'b1; end
      PS_WARM:  osc_on = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import pwr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CLKS   = 24,
  parameter int STAB_CLKS   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_pin,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              irq_pend,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              osc_en,
  output logic              int_rst,
  output logic              ram_clr,
  output logic [1:0]        mode_q
);
  logic [1:0] arst_sync_q;
  logic       arst_n;
  pwr_state_e state;
  logic       qual_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arst_sync_q <= 2'b00;
    else        arst_sync_q <= {arst_sync_q[0], 1'b1};
  end
  assign arst_n = arst_sync_q[1];

  pwr_rst_qual #(.SYNC_STAGES(SYNC_STAGES), .QUAL_CLKS(QUAL_CLKS)) u_qual (
    .clk      (clk),
    .arst_n   (arst_n),
    .pin_raw  (rst_pin),
    .qual_rst (qual_rst)
  );

  pwr_mode_fsm #(.DATA_W(DATA_W), .STAB_CLKS(STAB_CLKS)) u_fsm (
    .clk      (clk),
    .arst_n   (arst_n),
    .wr_en    (reg_wr),
    .wr_data  (reg_wdata),
    .irq_req  (irq_pend),
    .qual_rst (qual_rst),
    .state_o  (state),
    .mode_o   (mode_q)
  );

  pwr_enable_dec u_dec (
    .state_i (state),
    .cpu_en  (cpu_clk_en),
    .per_en  (per_clk_en),
    .osc_on  (osc_en)
  );

  assign int_rst = qual_rst;
  assign ram_clr = 1'b0;
endmodule

// File: rtl/pwr_sleep_chk.sv
module pwr_sleep_chk #(
  parameter int QUAL_CLKS = 24,
  parameter int STAB_CLKS = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_pin,
  input logic       reg_wr,
  input logic [1:0] wdata_lo,
  input logic       irq_pend,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       osc_en,
  input logic       int_rst,
  input logic [1:0] mode_q
);
  int pin_run;
  int warm_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_run  <= 0;
      warm_run <= 0;
    end else begin
      if (!rst_pin)                    pin_run <= 0;
      else if (pin_run < QUAL_CLKS + 8) pin_run <= pin_run + 1;
      if (osc_en && !per_clk_en) begin
        if (warm_run < STAB_CLKS + 8) warm_run <= warm_run + 1;
      end else begin
        warm_run <= 0;
      end
    end
  end

  a_r2_idle_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && reg_wr && wdata_lo == 2'b01 && !int_rst)
      |=> (!cpu_clk_en && per_clk_en && osc_en && mode_q == 2'b01));

  a_r3_pdown_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && reg_wr && wdata_lo[1] && !int_rst) |=> !osc_en);

  a_r4_irq_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && per_clk_en && irq_pend && !int_rst)
      |=> (cpu_clk_en && !mode_q[0]));

  a_r5_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (!cpu_clk_en && !per_clk_en));

  a_r5_pdown_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && !int_rst) |=> !osc_en);

  a_r7_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_rst) |-> pin_run >= QUAL_CLKS);

  a_r8_mode_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst |=> mode_q == 2'b00);

  a_r8_settled: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && !$past(per_clk_en)) |-> warm_run >= STAB_CLKS);
endmodule

bind pwr_sleep_ctrl pwr_sleep_chk #(.QUAL_CLKS(QUAL_CLKS), .STAB_CLKS(STAB_CLKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_pin    (rst_pin),
  .reg_wr     (reg_wr),
  .wdata_lo   (reg_wdata[1:0]),
  .irq_pend   (irq_pend),
  .cpu_clk_en (cpu_clk_en),
  .per_clk_en (per_clk_en),
  .osc_en     (osc_en),
  .int_rst    (int_rst),
  .mode_q     (mode_q)
);

// File: tb/sim_pwr_sleep_ctrl.sv
module sim_pwr_sleep_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int STAB = 16;
  localparam int QUAL = 24;

  // observed vector: {int_rst, osc_en, per_clk_en, cpu_clk_en, ram_clr, mode_q[1:0]}
  localparam logic [6:0] V_RUN    = 7'b0111000;
  localparam logic [6:0] V_IDLE   = 7'b0110001;
  localparam logic [6:0] V_PD11   = 7'b0000011;
  localparam logic [6:0] V_PD10   = 7'b0000010;
  localparam logic [6:0] V_PD11_R = 7'b1000011;
  localparam logic [6:0] V_WARM_R = 7'b1100000;
  localparam logic [6:0] V_RUN_R  = 7'b1111000;
  localparam logic [6:0] V_IDLE_R = 7'b1110001;

  logic       clk = 1'b0;
  logic       rst_n, rst_pin, reg_wr, irq_pend;
  logic [7:0] reg_wdata;
  logic       cpu_clk_en, per_clk_en, osc_en, int_rst, ram_clr;
  logic [1:0] mode_q;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  typedef struct {
    int         at;
    logic [6:0] val;
    string      tag;
  } exp_t;
  exp_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwr_sleep_ctrl #(.DATA_W(8), .SYNC_STAGES(2), .QUAL_CLKS(QUAL), .STAB_CLKS(STAB)) u0 (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .irq_pend(irq_pend), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .osc_en(osc_en), .int_rst(int_rst),
    .ram_clr(ram_clr), .mode_q(mode_q)
  );

  task automatic push(input int off, input logic [6:0] v, input string tag);
    exp_t e;
    e.at = cyc + off; e.val = v; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare every expectation due in this cycle
  always @(negedge clk) begin
    logic [6:0] obs;
    obs = {int_rst, osc_en, per_clk_en, cpu_clk_en, ram_clr, mode_q};
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].at == cyc) begin
        checks++;
        if (obs !== sbq[i].val) begin
          fails++;
          $display("FAIL %s cycle %0d: actual %b expected %b", sbq[i].tag, cyc, obs, sbq[i].val);
        end
        sbq.delete(i);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rst_pin = 1'b0; reg_wr = 1'b0; irq_pend = 1'b0; reg_wdata = '0;
    step(3);
    rst_n = 1'b1;
    step(4);
    push(1, V_RUN, "R1 reset state, R9 no ram clear");

    // R2 idle entry and hold
    step(1);
    reg_wr = 1'b1; reg_wdata = 8'h01;
    push(1, V_IDLE, "R2 idle entry");
    step(1);
    reg_wr = 1'b0;
    push(3, V_IDLE, "R2 idle hold");
    step(4);

    // R4 interrupt ends idle
    irq_pend = 1'b1;
    push(1, V_RUN, "R4 idle exit");
    step(1);
    irq_pend = 1'b0;
    step(1);

    // R6 interrupt while running does nothing
    irq_pend = 1'b1;
    push(1, V_RUN, "R6 irq in run");
    push(2, V_RUN, "R6 irq in run");
    step(2);
    irq_pend = 1'b0;

    // R2 upper data bits have no effect
    reg_wr = 1'b1; reg_wdata = 8'hFC;
    push(1, V_RUN, "R2 upper bits ignored");
    step(1);
    reg_wr = 1'b0;
    step(1);

    // R3 both bits set: power-down wins
    reg_wr = 1'b1; reg_wdata = 8'h03;
    push(1, V_PD11, "R3 both bits");
    step(1);
    reg_wr = 1'b0;
    irq_pend = 1'b1;
    push(2, V_PD11, "R5 irq in power-down");
    step(2);
    irq_pend = 1'b0;
    reg_wr = 1'b1; reg_wdata = 8'h00;
    push(1, V_PD11, "R6 write in power-down");
    step(1);
    reg_wr = 1'b0;
    step(1);

    // R7 and R8: qualified reset leaves power-down
    rst_pin = 1'b1;
    push(25, V_PD11, "R7 not yet qualified");
    push(26, V_PD11_R, "R7 reset asserted");
    push(27, V_WARM_R, "R8 oscillator first");
    push(26 + STAB, V_WARM_R, "R8 last settle cycle");
    push(27 + STAB, V_RUN_R, "R8 clocks restored");
    step(28);
    reg_wr = 1'b1; reg_wdata = 8'h01;
    push(1, V_WARM_R, "R6 write while settling");
    step(1);
    reg_wr = 1'b0;
    step(STAB + 1);
    rst_pin = 1'b0;
    push(2, V_RUN_R, "R7 reset still high");
    push(3, V_RUN, "R7 reset released");
    step(4);

    // R7 restart of qualification, R8 reset ends idle
    reg_wr = 1'b1; reg_wdata = 8'h01;
    push(1, V_IDLE, "R2 idle entry");
    step(1);
    reg_wr = 1'b0;
    rst_pin = 1'b1;
    push(20, V_IDLE, "R7 short pulse");
    step(20);
    rst_pin = 1'b0;
    step(1);
    rst_pin = 1'b1;
    push(6, V_IDLE, "R7 count restarted");
    push(25, V_IDLE, "R7 count restarted");
    push(26, V_IDLE_R, "R7 reset after restart");
    push(27, V_RUN_R, "R8 reset ends idle");
    step(28);
    rst_pin = 1'b0;
    push(3, V_RUN, "R7 reset released");
    step(4);

    // R3 power-down with bit 1 alone
    reg_wr = 1'b1; reg_wdata = 8'h02;
    push(1, V_PD10, "R3 power-down bit alone");
    step(1);
    reg_wr = 1'b0;
    irq_pend = 1'b1;
    push(3, V_PD10, "R5 irq in power-down");
    step(4);
    irq_pend = 1'b0;
    step(2);

    if (sbq.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sbq.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule